// File: doc/BRIEF.md
# DMA Fault Recording Unit

This block sits beside an I/O address-translation unit and turns a translation or permission violation into something software can see. Each translated request arrives with a flag saying whether it faulted. A faulting request is never passed on towards memory. The first fault after the record has been cleared is captured in a single record slot. The slot holds the requester's bus/device/function number, the faulting address, whether the access was a write, and a reason code. A pending flag is set, and a message-signalled interrupt goes out as a single write beat so that software does not have to poll.

Software reads the record through a small word-addressed register port. It acknowledges the fault by writing one to the pending flag. Faults that arrive while the slot is still occupied are dropped, and a sticky overflow flag records that they happened. A mask bit holds back the interrupt write. If the mask is lifted while a recorded fault is still pending, the held-back write goes out then. The interrupt is a single beat on a valid/ready channel, carrying a programmable address and data word.

Top module: `dma_fault_recorder`

## Requirements
- R1: `mem_valid` equals `xlat_valid` when `xlat_fault` is 0 and is 0 whenever `xlat_fault` is 1, in the same cycle.
- R2: A fault (`xlat_valid` and `xlat_fault` high at a clock edge) that arrives while pending is clear is captured at that edge. Word 2 reads {reason[31:24], 7'b0, write flag[16], source id[15:0]}, word 3 reads address[31:0], and word 4 reads the address bits above 31, zero-extended.
- R3: Word 0 bit 0 (pending) is set by a captured fault. Writing 1 to that bit clears it, and writing 0 leaves it unchanged.
- R4: A fault that arrives while pending is set leaves the record unchanged and sets word 0 bit 1 (overflow). Overflow is sticky and is cleared by writing 1 to it.
- R5: With the mask clear and the interrupt channel idle, `msi_valid` is high right after the capturing edge. `msi_addr` equals {word 6, word 5} and `msi_data` equals word 7.
- R6: While `msi_valid` is high and `msi_ready` is low, `msi_valid`, `msi_addr` and `msi_data` hold steady. The beat completes at the first edge with `msi_ready` high, and `msi_valid` then drops.
- R7: Word 1 bit 0 masks the interrupt: no write is issued while it is set. When it is cleared with pending still set, `msi_valid` rises one edge after the edge that wrote the clear. If pending is cleared while masked, no write is ever issued for that fault.
- R8: Each captured fault yields exactly one interrupt beat, and dropped (overflow) faults yield none.
- R9: After reset, words 0, 1, 5, 6 and 7 read 0 and `msi_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xlat_valid | input | 1 | Translated request present |
| xlat_fault | input | 1 | Request violated translation or permission |
| xlat_src_id | input | SRC_W | Requester bus/device/function |
| xlat_addr | input | ADDR_W | Requested input address |
| xlat_is_write | input | 1 | Request is a write |
| xlat_reason | input | RSN_W | Violation reason code |
| mem_valid | output | 1 | Request allowed to proceed to memory |
| reg_addr | input | 3 | Register word index |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| msi_valid | output | 1 | Interrupt write beat valid |
| msi_ready | input | 1 | Interrupt write accepted |
| msi_addr | output | 64 | Interrupt write address |
| msi_data | output | 32 | Interrupt write data |

## Verification
The forwarding decision is combinational, so the bench reads `mem_valid` a moment after driving the request. Every other result is registered. The record, pending, overflow and an unmasked interrupt beat all appear right after the edge that sampled the fault, and the bench reads them 1 ns after that edge. A masked interrupt appears one edge after the edge that wrote the mask clear, and the bench checks that it is still low after the first of those edges and high after the second. Completed interrupt beats are counted at falling edges, so the count of one beat per captured fault can be checked exactly.

// File: rtl/dfr_pkg.sv
package dfr_pkg;
  localparam int REG_IDX_W   = 3;
  localparam int REG_W       = 32;
  localparam int MSI_ADDR_W  = 64;

  localparam logic [REG_IDX_W-1:0] IDX_STATUS  = 3'd0;
  localparam logic [REG_IDX_W-1:0] IDX_CTRL    = 3'd1;
  localparam logic [REG_IDX_W-1:0] IDX_REC_ID  = 3'd2;
  localparam logic [REG_IDX_W-1:0] IDX_REC_ALO = 3'd3;
  localparam logic [REG_IDX_W-1:0] IDX_REC_AHI = 3'd4;
  localparam logic [REG_IDX_W-1:0] IDX_MSI_ALO = 3'd5;
  localparam logic [REG_IDX_W-1:0] IDX_MSI_AHI = 3'd6;
  localparam logic [REG_IDX_W-1:0] IDX_MSI_DAT = 3'd7;

  localparam int BIT_PEND   = 0;
  localparam int BIT_OVF    = 1;
  localparam int BIT_MASK   = 0;
  localparam int BIT_WRITE  = 16;
  localparam int RSN_LSB    = 24;
  localparam int SRC_MAX_W  = 16;
  localparam int RSN_MAX_W  = 8;
endpackage

// File: rtl/dfr_capture.sv
module dfr_capture #(
  parameter int SRC_W  = 16,
  parameter int ADDR_W = 48,
  parameter int RSN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fault_hit,
  input  logic [SRC_W-1:0]  src_id,
  input  logic [ADDR_W-1:0] addr,
  input  logic              is_write,
  input  logic [RSN_W-1:0]  reason,
  input  logic              clr_pend,
  input  logic              clr_ovf,
  output logic              accept,
  output logic              pend_q,
  output logic              ovf_q,
  output logic [SRC_W-1:0]  rec_src_q,
  output logic [ADDR_W-1:0] rec_addr_q,
  output logic              rec_wr_q,
  output logic [RSN_W-1:0]  rec_rsn_q
);
  logic pend_d, ovf_d;

  always_comb begin
    accept = fault_hit & ~pend_q;
    pend_d = accept | (pend_q & ~clr_pend);
    ovf_d  = (fault_hit & pend_q) | (ovf_q & ~clr_ovf);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      ovf_q  <= ovf_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_src_q  <= '0;
      rec_addr_q <= '0;
      rec_wr_q   <= 1'b0;
      rec_rsn_q  <= '0;
    end else if (accept) begin
      rec_src_q  <= src_id;
      rec_addr_q <= addr;
      rec_wr_q   <= is_write;
      rec_rsn_q  <= reason;
    end
  end
endmodule

// File: rtl/dfr_regs.sv
module dfr_regs
  import dfr_pkg::*;
#(
  parameter int SRC_W  = 16,
  parameter int ADDR_W = 48,
  parameter int RSN_W  = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [REG_IDX_W-1:0]  reg_addr,
  input  logic                  reg_wr_en,
  input  logic [REG_W-1:0]      reg_wdata,
  output logic [REG_W-1:0]      reg_rdata,
  input  logic                  pend,
  input  logic                  ovf,
  input  logic [SRC_W-1:0]      rec_src,
  input  logic [ADDR_W-1:0]     rec_addr,
  input  logic                  rec_wr,
  input  logic [RSN_W-1:0]      rec_rsn,
  output logic                  clr_pend,
  output logic                  clr_ovf,
  output logic                  mask_q,
  output logic [MSI_ADDR_W-1:0] cfg_addr_q,
  output logic [REG_W-1:0]      cfg_data_q
);
  localparam int HALF = MSI_ADDR_W / 2;

  logic wr_status, wr_ctrl, wr_alo, wr_ahi, wr_dat;
  logic [MSI_ADDR_W-1:0] rec_addr64;
  logic [REG_W-1:0] id_word;

  always_comb begin
    wr_status = reg_wr_en && (reg_addr == IDX_STATUS);
    wr_ctrl   = reg_wr_en && (reg_addr == IDX_CTRL);
    wr_alo    = reg_wr_en && (reg_addr == IDX_MSI_ALO);
    wr_ahi    = reg_wr_en && (reg_addr == IDX_MSI_AHI);
    wr_dat    = reg_wr_en && (reg_addr == IDX_MSI_DAT);
    clr_pend  = wr_status & reg_wdata[BIT_PEND];
    clr_ovf   = wr_status & reg_wdata[BIT_OVF];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= 1'b0;
    else if (wr_ctrl) mask_q <= reg_wdata[BIT_MASK];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_addr_q[HALF-1:0] <= '0;
    else if (wr_alo) cfg_addr_q[HALF-1:0] <= reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_addr_q[MSI_ADDR_W-1:HALF] <= '0;
    else if (wr_ahi) cfg_addr_q[MSI_ADDR_W-1:HALF] <= reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_data_q <= '0;
    else if (wr_dat) cfg_data_q <= reg_wdata;
  end

  always_comb begin
    rec_addr64 = MSI_ADDR_W'(rec_addr);
    id_word = '0;
    id_word[SRC_MAX_W-1:0]        = SRC_MAX_W'(rec_src);
    id_word[BIT_WRITE]            = rec_wr;
    id_word[RSN_LSB +: RSN_MAX_W] = RSN_MAX_W'(rec_rsn);
    case (reg_addr)
      IDX_STATUS:  reg_rdata = {30'b0, ovf, pend};
      IDX_CTRL:    reg_rdata = {31'b0, mask_q};
      IDX_REC_ID:  reg_rdata = id_word;
      IDX_REC_ALO: reg_rdata = rec_addr64[HALF-1:0];
      IDX_REC_AHI: reg_rdata = rec_addr64[MSI_ADDR_W-1:HALF];
      IDX_MSI_ALO: reg_rdata = cfg_addr_q[HALF-1:0];
      IDX_MSI_AHI: reg_rdata = cfg_addr_q[MSI_ADDR_W-1:HALF];
      default:     reg_rdata = cfg_data_q;
    endcase
  end
endmodule

// File: rtl/dfr_msi.sv
module dfr_msi
  import dfr_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  accept,
  input  logic                  pend,
  input  logic                  mask,
  input  logic [MSI_ADDR_W-1:0] cfg_addr,
  input  logic [REG_W-1:0]      cfg_data,
  input  logic                  msi_ready,
  output logic                  msi_valid,
  output logic [MSI_ADDR_W-1:0] msi_addr,
  output logic [REG_W-1:0]      msi_data
);
  logic defer_q, defer_d, valid_d;
  logic busy, launch_new, launch_def, launch;

  always_comb begin
    busy       = msi_valid & ~msi_ready;
    launch_new = accept & ~mask & ~busy;
    launch_def = defer_q & pend & ~mask & ~busy;
    launch     = launch_new | launch_def;
    defer_d    = (accept & (mask | busy)) | (defer_q & pend & ~launch_def);
    valid_d    = launch | busy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      defer_q   <= 1'b0;
      msi_valid <= 1'b0;
    end else begin
      defer_q   <= defer_d;
      msi_valid <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msi_addr <= '0;
      msi_data <= '0;
    end else if (launch) begin
      msi_addr <= cfg_addr;
      msi_data <= cfg_data;
    end
  end
endmodule

// File: rtl/dma_fault_recorder.sv
module dma_fault_recorder
  import dfr_pkg::*;
#(
  parameter int SRC_W  = 16,
  parameter int ADDR_W = 48,
  parameter int RSN_W  = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  xlat_valid,
  input  logic                  xlat_fault,
  input  logic [SRC_W-1:0]      xlat_src_id,
  input  logic [ADDR_W-1:0]     xlat_addr,
  input  logic                  xlat_is_write,
  input  logic [RSN_W-1:0]      xlat_reason,
  output logic                  mem_valid,
  input  logic [REG_IDX_W-1:0]  reg_addr,
  input  logic                  reg_wr_en,
  input  logic [REG_W-1:0]      reg_wdata,
  output logic [REG_W-1:0]      reg_rdata,
  output logic                  msi_valid,
  input  logic                  msi_ready,
  output logic [MSI_ADDR_W-1:0] msi_addr,
  output logic [REG_W-1:0]      msi_data
);
  logic rst_s1_q, rst_s2_q;
  logic fault_hit, accept, pend_q, ovf_q, clr_pend, clr_ovf, mask_q, rec_wr;
  logic [SRC_W-1:0]      rec_src;
  logic [ADDR_W-1:0]     rec_addr;
  logic [RSN_W-1:0]      rec_rsn;
  logic [MSI_ADDR_W-1:0] cfg_addr;
  logic [REG_W-1:0]      cfg_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  always_comb begin
    fault_hit = xlat_valid & xlat_fault;
    mem_valid = xlat_valid & ~xlat_fault;
  end

  dfr_capture #(.SRC_W(SRC_W), .ADDR_W(ADDR_W), .RSN_W(RSN_W)) u_cap (
    .clk(clk), .rst_n(rst_s2_q), .fault_hit(fault_hit),
    .src_id(xlat_src_id), .addr(xlat_addr), .is_write(xlat_is_write),
    .reason(xlat_reason), .clr_pend(clr_pend), .clr_ovf(clr_ovf),
    .accept(accept), .pend_q(pend_q), .ovf_q(ovf_q),
    .rec_src_q(rec_src), .rec_addr_q(rec_addr), .rec_wr_q(rec_wr),
    .rec_rsn_q(rec_rsn)
  );

  dfr_regs #(.SRC_W(SRC_W), .ADDR_W(ADDR_W), .RSN_W(RSN_W)) u_regs (
    .clk(clk), .rst_n(rst_s2_q), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pend(pend_q), .ovf(ovf_q),
    .rec_src(rec_src), .rec_addr(rec_addr), .rec_wr(rec_wr), .rec_rsn(rec_rsn),
    .clr_pend(clr_pend), .clr_ovf(clr_ovf), .mask_q(mask_q),
    .cfg_addr_q(cfg_addr), .cfg_data_q(cfg_data)
  );

  dfr_msi u_msi (
    .clk(clk), .rst_n(rst_s2_q), .accept(accept), .pend(pend_q), .mask(mask_q),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data), .msi_ready(msi_ready),
    .msi_valid(msi_valid), .msi_addr(msi_addr), .msi_data(msi_data)
  );
endmodule

// File: rtl/dma_fault_recorder_chk.sv
module dma_fault_recorder_chk #(
  parameter int ADDR_W = 48
) (
  input logic              clk,
  input logic              rst_n,
  input logic              xlat_valid,
  input logic              xlat_fault,
  input logic              mem_valid,
  input logic              pend_q,
  input logic              ovf_q,
  input logic              mask_q,
  input logic [ADDR_W-1:0] rec_addr,
  input logic              msi_valid,
  input logic              msi_ready,
  input logic [63:0]       msi_addr,
  input logic [31:0]       msi_data
);
  assert_fault_blocked_R1: assert property (@(posedge clk) disable iff (!rst_n)
    xlat_fault |-> !mem_valid);

  assert_record_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && xlat_valid && xlat_fault) |=> $stable(rec_addr));

  assert_overflow_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && xlat_valid && xlat_fault) |=> ovf_q);

  assert_pending_on_fault_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (xlat_valid && xlat_fault) |=> pend_q);

  assert_msi_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (msi_valid && !msi_ready) |=> (msi_valid && $stable(msi_addr) && $stable(msi_data)));

  assert_mask_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msi_valid) |-> !$past(mask_q));
endmodule

bind dma_fault_recorder dma_fault_recorder_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .xlat_valid(xlat_valid), .xlat_fault(xlat_fault),
  .mem_valid(mem_valid), .pend_q(pend_q), .ovf_q(ovf_q), .mask_q(mask_q),
  .rec_addr(rec_addr), .msi_valid(msi_valid), .msi_ready(msi_ready),
  .msi_addr(msi_addr), .msi_data(msi_data)
);

// File: tb/dma_fault_recorder_tb_top.sv
module dma_fault_recorder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xlat_valid = 1'b0, xlat_fault = 1'b0, xlat_is_write = 1'b0;
  logic [15:0] xlat_src_id = '0;
  logic [47:0] xlat_addr = '0;
  logic [7:0]  xlat_reason = '0;
  logic        mem_valid;
  logic [2:0]  reg_addr = '0;
  logic        reg_wr_en = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        msi_valid, msi_ready = 1'b0;
  logic [63:0] msi_addr;
  logic [31:0] msi_data;

  int errors = 0;
  int checks = 0;
  int msi_count = 0;

  always #5 clk = ~clk;

  dma_fault_recorder dut_i (
    .clk(clk), .rst_n(rst_n), .xlat_valid(xlat_valid), .xlat_fault(xlat_fault),
    .xlat_src_id(xlat_src_id), .xlat_addr(xlat_addr), .xlat_is_write(xlat_is_write),
    .xlat_reason(xlat_reason), .mem_valid(mem_valid), .reg_addr(reg_addr),
    .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .msi_valid(msi_valid), .msi_ready(msi_ready), .msi_addr(msi_addr),
    .msi_data(msi_data)
  );

  always @(negedge clk) if (rst_n && msi_valid && msi_ready) msi_count++;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
    step();
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [2:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    chk(tag, {32'b0, reg_rdata}, {32'b0, exp});
  endtask

  task automatic fault(input logic [15:0] s, input logic [47:0] ad,
                       input logic w, input logic [7:0] r);
    xlat_valid = 1'b1; xlat_fault = 1'b1;
    xlat_src_id = s; xlat_addr = ad; xlat_is_write = w; xlat_reason = r;
    step();
    xlat_valid = 1'b0; xlat_fault = 1'b0;
  endtask

  task automatic t_reset();
    rd("R9 status", 3'd0, 32'h0);
    rd("R9 ctrl", 3'd1, 32'h0);
    rd("R9 msi addr lo", 3'd5, 32'h0);
    rd("R9 msi addr hi", 3'd6, 32'h0);
    rd("R9 msi data", 3'd7, 32'h0);
    chk("R9 msi_valid", {63'b0, msi_valid}, 64'd0);
  endtask

  task automatic t_forward();
    xlat_valid = 1'b1; xlat_fault = 1'b0; #1;
    chk("R1 clean forwarded", {63'b0, mem_valid}, 64'd1);
    xlat_fault = 1'b1; #1;
    chk("R1 fault blocked", {63'b0, mem_valid}, 64'd0);
    xlat_valid = 1'b0; xlat_fault = 1'b0; #1;
    chk("R1 idle", {63'b0, mem_valid}, 64'd0);
  endtask

  task automatic t_record();
    int base;
    wr(3'd5, 32'hFEE0_1000);
    wr(3'd6, 32'h0000_0001);
    wr(3'd7, 32'h0000_00A5);
    msi_ready = 1'b0;
    base = msi_count;
    fault(16'h1A2B, 48'hABCD_1234_5678, 1'b1, 8'h05);
    rd("R3 pending set", 3'd0, 32'h1);
    rd("R2 id word", 3'd2, 32'h0501_1A2B);
    rd("R2 addr lo", 3'd3, 32'h1234_5678);
    rd("R2 addr hi", 3'd4, 32'h0000_ABCD);
    chk("R5 msi_valid", {63'b0, msi_valid}, 64'd1);
    chk("R5 msi_addr", msi_addr, 64'h0000_0001_FEE0_1000);
    chk("R5 msi_data", {32'b0, msi_data}, 64'h0000_00A5);
    step(); step(); step();
    chk("R6 held valid", {63'b0, msi_valid}, 64'd1);
    chk("R6 held addr", msi_addr, 64'h0000_0001_FEE0_1000);
    msi_ready = 1'b1;
    step();
    chk("R6 beat done", {63'b0, msi_valid}, 64'd0);
    chk("R8 one beat", 64'(msi_count - base), 64'd1);
    wr(3'd0, 32'h0);
    rd("R3 write zero keeps", 3'd0, 32'h1);
    wr(3'd0, 32'h1);
    rd("R3 w1c clears", 3'd0, 32'h0);
  endtask

  task automatic t_overflow();
    int base;
    msi_ready = 1'b1;
    base = msi_count;
    fault(16'h0042, 48'h0000_0000_1000, 1'b0, 8'h02);
    step();
    fault(16'h0099, 48'h0000_0000_2000, 1'b1, 8'h07);
    rd("R4 pend and ovf", 3'd0, 32'h3);
    rd("R4 record kept id", 3'd2, 32'h0200_0042);
    rd("R4 record kept addr", 3'd3, 32'h0000_1000);
    chk("R8 no msi for drop", {63'b0, msi_valid}, 64'd0);
    step();
    chk("R8 single beat", 64'(msi_count - base), 64'd1);
    wr(3'd0, 32'h2);
    rd("R4 ovf w1c", 3'd0, 32'h1);
    wr(3'd0, 32'h1);
    rd("R4 all clear", 3'd0, 32'h0);
  endtask

  task automatic t_mask();
    int base;
    msi_ready = 1'b0;
    base = msi_count;
    wr(3'd1, 32'h1);
    fault(16'h0300, 48'h0000_0000_3000, 1'b0, 8'h01);
    step(); step();
    chk("R7 masked no msi", {63'b0, msi_valid}, 64'd0);
    wr(3'd1, 32'h0);
    chk("R7 not yet", {63'b0, msi_valid}, 64'd0);
    step();
    chk("R7 deferred msi", {63'b0, msi_valid}, 64'd1);
    msi_ready = 1'b1;
    step();
    chk("R7 deferred single", 64'(msi_count - base), 64'd1);
    wr(3'd0, 32'h1);
  endtask

  task automatic t_mask_drop();
    int base;
    msi_ready = 1'b1;
    base = msi_count;
    wr(3'd1, 32'h1);
    fault(16'h0400, 48'h0000_0000_4000, 1'b1, 8'h03);
    wr(3'd0, 32'h1);
    wr(3'd1, 32'h0);
    step(); step(); step();
    chk("R7 dropped no msi", 64'(msi_count - base), 64'd0);
    rd("R3 cleared", 3'd0, 32'h0);
  endtask

  task automatic t_second();
    int base;
    msi_ready = 1'b1;
    base = msi_count;
    wr(3'd7, 32'h0000_0077);
    fault(16'hFFFF, 48'hFFFF_FFFF_FFFF, 1'b0, 8'hFF);
    rd("R2 max id word", 3'd2, 32'hFF00_FFFF);
    rd("R2 max addr hi", 3'd4, 32'h0000_FFFF);
    chk("R5 new data", {32'b0, msi_data}, 64'h77);
    step();
    chk("R8 new fault beat", 64'(msi_count - base), 64'd1);
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(); step();
    rst_n = 1'b1;
    step(); step(); step();
    t_reset();
    t_forward();
    t_record();
    t_overflow();
    t_mask();
    t_mask_drop();
    t_second();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule